// File: doc/BRIEF.md
# Time Slot Switch Host Register Port

This block is the host-side slave of a time slot interchange switch. It lets a processor reach three things over a small parallel bus: one 8-bit mode register, and the storage of the switch. That storage is a receive data store plus a two-half connection store. One half holds the source selections or processor bytes, the other holds the per-channel control bits. The bus has a synchronous chip select, separate read and write strobes, and a 6-bit address. The top address bit splits the space in two. With that bit clear, the access goes to the mode register. With it set, the five low lines name one of 32 channels. The stream field and the store-select field of the mode register supply the rest of the memory location.

The block does not contain the stores. It drives a combined memory address, per-store read enables and write enables, and write data. It takes the read data back from each store in the same cycle and registers it onto the bus one cycle later. It also brings out two global mode bits to the switching datapath. The first forces every output channel to take its byte from the connection store. The second is a split mode: memory-space reads always come from the receive data store, while writes still follow the store-select field.

Top module: `tsi_cpu_port`

## Requirements
- R1: After reset the mode register is zero, the read data bus is zero, and both `proc_all` and `split_mode` are low.
- R2: A write with `addr[5]`=0 loads the mode register, and a read with `addr[5]`=0 returns it. The bit layout is: bit 7 split, bit 6 force-processor, bit 5 reserved (always reads 0, written value dropped), bits 4:3 store select, bits 2:0 stream.
- R3: `proc_all` always equals mode bit 6 and `split_mode` always equals mode bit 7.
- R4: During a memory-space access (`addr[5]`=1), `mem_addr` equals {mode bits 2:0, `addr[4:0]`}, so the stream number sits in `mem_addr[7:5]`.
- R5: With split clear, a memory-space read returns data according to the store select. 00 returns zero. 01 returns the data store. 10 returns the connection low half. 11 returns the connection high half. Only the matching read enable is raised.
- R6: A memory-space write raises `cml_we` for select 10 and `cmh_we` for select 11. Selects 00 and 01 raise no write enable, so the stores keep their contents. The split bit does not change where writes go.
- R7: With split set, every memory-space read returns the data store and raises only `dm_rd_en`, whatever the store select.
- R8: Read data appears on `rdata` in the cycle after the read strobe is sampled. It holds its value until the next accepted read.
- R9: With `cs` low, strobes have no effect. When `rd` and `wr` are both high, only the write is performed and `rdata` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Synchronous chip select |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| addr | input | 6 | Bit 5 selects memory space; bits 4:0 channel |
| wdata | input | 8 | Write data from the host |
| rdata | output | 8 | Registered read data to the host |
| mem_addr | output | 8 | Combined stream and channel address to the stores |
| mem_wdata | output | 8 | Write data to the connection store halves |
| dm_rd_en | output | 1 | Read enable for the receive data store |
| cml_rd_en | output | 1 | Read enable for the connection low half |
| cmh_rd_en | output | 1 | Read enable for the connection high half |
| cml_we | output | 1 | Write enable for the connection low half |
| cmh_we | output | 1 | Write enable for the connection high half |
| dm_rdata | input | 8 | Data store read data, valid in the strobe cycle |
| cml_rdata | input | 8 | Connection low read data, valid in the strobe cycle |
| cmh_rdata | input | 8 | Connection high read data, valid in the strobe cycle |
| proc_all | output | 1 | Global force-processor mode bit |
| split_mode | output | 1 | Global split-access mode bit |

## Verification
The bench sweeps every combination of store select and split bit over several streams, including channels 0 and 31 and stream 7. A design that routed split reads by the select field would return connection bytes where data-store bytes are expected. Attempted writes with selects 00 and 01 are followed by reads of the same location through a writable select. A stray write enable would then show up as a changed byte. The reserved mode bit is written high and read back, and accesses with chip select low, or with both strobes high, check that `rdata` and the stores stay untouched. A design with a zero-cycle or two-cycle read path would be off by one on every comparison.

// File: rtl/tsi_cpu_pkg.sv
package tsi_cpu_pkg;

   // Store select encoding (mode register bits 4:3)
   typedef enum logic [1:0] {
      SEL_NONE   = 2'b00,
      SEL_DATA   = 2'b01,
      SEL_CONN_L = 2'b10,
      SEL_CONN_H = 2'b11
   } store_sel_e;

   localparam int MODE_W    = 8;
   localparam int STREAM_FW = 3;   // width of the stream field in the mode byte
   localparam int BIT_SPLIT = 7;
   localparam int BIT_PROC  = 6;
   localparam int BIT_RSV   = 5;
   localparam int SEL_HI    = 4;
   localparam int SEL_LO    = 3;

   typedef struct packed {
      logic                 split;
      logic                 proc;
      store_sel_e           sel;
      logic [STREAM_FW-1:0] stream;
   } mode_s;

endpackage

// File: rtl/tsi_mode_reg.sv
module tsi_mode_reg
   import tsi_cpu_pkg::*;
#(
   parameter int STREAM_AW = 3
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [MODE_W-1:0] din,
   output mode_s             mode,
   output logic [MODE_W-1:0] mode_byte
);

   if (STREAM_AW < 1 || STREAM_AW > STREAM_FW) begin : g_bad_stream
      $error("tsi_mode_reg: STREAM_AW must be 1..3");
   end

   mode_s q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else if (load) begin
         q.split  <= din[BIT_SPLIT];
         q.proc   <= din[BIT_PROC];
         q.sel    <= store_sel_e'(din[SEL_HI:SEL_LO]);
         q.stream <= '0;
         q.stream[STREAM_AW-1:0] <= din[STREAM_AW-1:0];
      end
   end

   // Unused stream bits read as zero when the stream field is narrowed
   logic [STREAM_FW-1:0] stream_rd;
   for (genvar i = 0; i < STREAM_FW; i++) begin : g_stream_bit
      if (i < STREAM_AW) begin : g_used
         assign stream_rd[i] = q.stream[i];
      end else begin : g_unused
         assign stream_rd[i] = 1'b0;
      end
   end

   assign mode = q;
   assign mode_byte = {q.split, q.proc, 1'b0, q.sel, stream_rd};

   // R9: without a load the register keeps its value
   p_mode_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(q));

endmodule

// File: rtl/tsi_bus_decode.sv
module tsi_bus_decode
   import tsi_cpu_pkg::*;
#(
   parameter int CH_AW     = 5,
   parameter int STREAM_AW = 3,
   localparam int AW       = CH_AW + 1,
   localparam int MAW      = STREAM_AW + CH_AW
)(
   input  logic           clk,
   input  logic           rst_n,
   input  logic           cs,
   input  logic           rd,
   input  logic           wr,
   input  logic [AW-1:0]  addr,
   input  mode_s          mode,
   output logic           mode_load,
   output logic           mode_read,
   output logic           mem_read,
   output store_sel_e     rd_sel,
   output logic [MAW-1:0] mem_addr,
   output logic           dm_rd_en,
   output logic           cml_rd_en,
   output logic           cmh_rd_en,
   output logic           cml_we,
   output logic           cmh_we
);

   logic acc_wr, acc_rd, in_mem;

   // Write wins over read when both strobes are high
   assign acc_wr = cs & wr;
   assign acc_rd = cs & rd & ~wr;
   assign in_mem = addr[CH_AW];

   assign mode_load = acc_wr & ~in_mem;
   assign mode_read = acc_rd & ~in_mem;
   assign mem_read  = acc_rd & in_mem;

   // Split mode steers every memory read to the data store
   assign rd_sel = mode.split ? SEL_DATA : mode.sel;

   assign mem_addr = {mode.stream[STREAM_AW-1:0], addr[CH_AW-1:0]};

   assign dm_rd_en  = mem_read && (rd_sel == SEL_DATA);
   assign cml_rd_en = mem_read && (rd_sel == SEL_CONN_L);
   assign cmh_rd_en = mem_read && (rd_sel == SEL_CONN_H);

   // Data store is filled by the receive path only: no host write path
   assign cml_we = acc_wr && in_mem && (mode.sel == SEL_CONN_L);
   assign cmh_we = acc_wr && in_mem && (mode.sel == SEL_CONN_H);

   // R7: split reads touch only the data store
   p_split_to_dm_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cs && rd && !wr && addr[CH_AW] && mode.split) |-> (dm_rd_en && !cml_rd_en && !cmh_rd_en));

   // R6: at most one store strobe in any cycle
   p_one_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cml_we, cmh_we, dm_rd_en, cml_rd_en, cmh_rd_en}));

   // R9: no store activity without chip select
   p_idle_no_cs_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !cs |-> !(cml_we || cmh_we || dm_rd_en || cml_rd_en || cmh_rd_en));

endmodule

// File: rtl/tsi_read_path.sv
module tsi_read_path
   import tsi_cpu_pkg::*;
#(
   parameter int DW = 8
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          mode_read,
   input  logic          mem_read,
   input  store_sel_e    rd_sel,
   input  logic [DW-1:0] mode_byte,
   input  logic [DW-1:0] dm_rdata,
   input  logic [DW-1:0] cml_rdata,
   input  logic [DW-1:0] cmh_rdata,
   output logic [DW-1:0] rdata
);

   logic [DW-1:0] mem_mux, next_rd;

   always_comb begin
      unique case (rd_sel)
         SEL_DATA:   mem_mux = dm_rdata;
         SEL_CONN_L: mem_mux = cml_rdata;
         SEL_CONN_H: mem_mux = cmh_rdata;
         default:    mem_mux = '0;
      endcase
   end

   assign next_rd = mode_read ? mode_byte : mem_mux;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     rdata <= '0;
      else if (mode_read || mem_read) rdata <= next_rd;
   end

   // R8: bus data holds between accepted reads
   p_rdata_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(mode_read || mem_read) |=> $stable(rdata));

endmodule

// File: rtl/tsi_cpu_port.sv
module tsi_cpu_port
   import tsi_cpu_pkg::*;
#(
   parameter int CH_AW     = 5,
   parameter int STREAM_AW = 3,
   parameter int DW        = 8,
   localparam int AW       = CH_AW + 1,
   localparam int MAW      = STREAM_AW + CH_AW
)(
   input  logic           clk,
   input  logic           rst_n,
   input  logic           cs,
   input  logic           rd,
   input  logic           wr,
   input  logic [AW-1:0]  addr,
   input  logic [DW-1:0]  wdata,
   output logic [DW-1:0]  rdata,
   output logic [MAW-1:0] mem_addr,
   output logic [DW-1:0]  mem_wdata,
   output logic           dm_rd_en,
   output logic           cml_rd_en,
   output logic           cmh_rd_en,
   output logic           cml_we,
   output logic           cmh_we,
   input  logic [DW-1:0]  dm_rdata,
   input  logic [DW-1:0]  cml_rdata,
   input  logic [DW-1:0]  cmh_rdata,
   output logic           proc_all,
   output logic           split_mode
);

   if (DW != MODE_W) begin : g_bad_dw
      $error("tsi_cpu_port: DW must equal the mode register width");
   end
   if (CH_AW < 1) begin : g_bad_ch
      $error("tsi_cpu_port: CH_AW must be at least 1");
   end

   mode_s       mode;
   logic [DW-1:0] mode_byte;
   logic        mode_load, mode_read, mem_read;
   store_sel_e  rd_sel;

   tsi_mode_reg #(.STREAM_AW(STREAM_AW)) u_mode (
      .clk(clk), .rst_n(rst_n), .load(mode_load), .din(wdata),
      .mode(mode), .mode_byte(mode_byte)
   );

   tsi_bus_decode #(.CH_AW(CH_AW), .STREAM_AW(STREAM_AW)) u_dec (
      .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
      .mode(mode), .mode_load(mode_load), .mode_read(mode_read),
      .mem_read(mem_read), .rd_sel(rd_sel), .mem_addr(mem_addr),
      .dm_rd_en(dm_rd_en), .cml_rd_en(cml_rd_en), .cmh_rd_en(cmh_rd_en),
      .cml_we(cml_we), .cmh_we(cmh_we)
   );

   tsi_read_path #(.DW(DW)) u_rd (
      .clk(clk), .rst_n(rst_n), .mode_read(mode_read), .mem_read(mem_read),
      .rd_sel(rd_sel), .mode_byte(mode_byte), .dm_rdata(dm_rdata),
      .cml_rdata(cml_rdata), .cmh_rdata(cmh_rdata), .rdata(rdata)
   );

   assign mem_wdata  = wdata;
   assign proc_all   = mode.proc;
   assign split_mode = mode.split;

   // R2: reserved bit is never seen by a mode register read
   p_rsv_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cs && rd && !wr && !addr[CH_AW]) |=> (rdata[BIT_RSV] == 1'b0));

   // R2: a mode write is reflected on the global outputs next cycle
   p_mode_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cs && wr && !addr[CH_AW]) |=> (proc_all == $past(wdata[BIT_PROC]) &&
                                      split_mode == $past(wdata[BIT_SPLIT])));

endmodule

// File: tb/tsi_cpu_port_test.sv
`timescale 1ns/1ps
module tsi_cpu_port_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs = 1'b0, rd = 1'b0, wr = 1'b0;
   logic [5:0] addr = '0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata, mem_addr, mem_wdata, dm_rdata, cml_rdata, cmh_rdata;
   logic       dm_rd_en, cml_rd_en, cmh_rd_en, cml_we, cmh_we, proc_all, split_mode;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   tsi_cpu_port uut (
      .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
      .wdata(wdata), .rdata(rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .dm_rd_en(dm_rd_en), .cml_rd_en(cml_rd_en), .cmh_rd_en(cmh_rd_en),
      .cml_we(cml_we), .cmh_we(cmh_we), .dm_rdata(dm_rdata),
      .cml_rdata(cml_rdata), .cmh_rdata(cmh_rdata),
      .proc_all(proc_all), .split_mode(split_mode)
   );

   // Environment stores, driven by the design's strobes
   logic [7:0] dm_env [256];
   logic [7:0] cml_env[256];
   logic [7:0] cmh_env[256];
   assign dm_rdata  = dm_env[mem_addr];
   assign cml_rdata = cml_env[mem_addr];
   assign cmh_rdata = cmh_env[mem_addr];
   always @(posedge clk) begin
      if (cml_we) cml_env[mem_addr] <= mem_wdata;
      if (cmh_we) cmh_env[mem_addr] <= mem_wdata;
   end

   // Reference model state
   logic [7:0] m_mode = '0;
   logic [7:0] m_rdata = '0;
   logic [7:0] dm_ref [256];
   logic [7:0] cml_ref[256];
   logic [7:0] cmh_ref[256];

   task automatic cmp(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic bus(input logic c, input logic r, input logic w,
                      input logic [5:0] a, input logic [7:0] d);
      logic       acc_w, acc_r, in_mem;
      logic [1:0] sel, rsel;
      int         loc;
      @(negedge clk);
      cs = c; rd = r; wr = w; addr = a; wdata = d;
      acc_w  = c & w;
      acc_r  = c & r & ~w;
      in_mem = a[5];
      sel    = m_mode[4:3];
      rsel   = m_mode[7] ? 2'b01 : sel;
      loc    = {m_mode[2:0], a[4:0]};
      #1;
      if (c && in_mem) cmp("R4", "mem_addr", mem_addr, loc);
      cmp("R6", "cml_we", cml_we, acc_w && in_mem && sel == 2'b10);
      cmp("R6", "cmh_we", cmh_we, acc_w && in_mem && sel == 2'b11);
      cmp(m_mode[7] ? "R7" : "R5", "dm_rd_en", dm_rd_en, acc_r && in_mem && rsel == 2'b01);
      cmp("R5", "cml_rd_en", cml_rd_en, acc_r && in_mem && rsel == 2'b10);
      cmp("R5", "cmh_rd_en", cmh_rd_en, acc_r && in_mem && rsel == 2'b11);
      @(posedge clk);
      if (acc_r) begin
         if (!in_mem) m_rdata = m_mode;
         else case (rsel)
            2'b01:   m_rdata = dm_ref[loc];
            2'b10:   m_rdata = cml_ref[loc];
            2'b11:   m_rdata = cmh_ref[loc];
            default: m_rdata = 8'h00;
         endcase
      end
      if (acc_w) begin
         if (!in_mem) m_mode = d & 8'hDF;
         else if (sel == 2'b10) cml_ref[loc] = d;
         else if (sel == 2'b11) cmh_ref[loc] = d;
      end
      #1;
      cmp("R8", "rdata", rdata, m_rdata);
      cmp("R3", "proc_all", proc_all, m_mode[6]);
      cmp("R3", "split_mode", split_mode, m_mode[7]);
   endtask

   task automatic set_mode(input logic [7:0] v); bus(1, 0, 1, 6'h00, v); endtask
   task automatic mwr(input logic [4:0] ch, input logic [7:0] v); bus(1, 0, 1, {1'b1, ch}, v); endtask
   task automatic mrd(input logic [4:0] ch); bus(1, 1, 0, {1'b1, ch}, 8'h00); endtask

   initial begin
      #(200000 * 5);
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      logic [7:0] lfsr;
      for (int i = 0; i < 256; i++) begin
         dm_env[i]  = 8'((i * 7 + 3) ^ (i >> 3));
         cml_env[i] = 8'(i ^ 8'h5A);
         cmh_env[i] = 8'((i * 13) ^ 8'hC3);
         dm_ref[i]  = dm_env[i];
         cml_ref[i] = cml_env[i];
         cmh_ref[i] = cmh_env[i];
      end
      repeat (3) @(posedge clk);
      #1;
      // R1: reset state
      cmp("R1", "rdata", rdata, 0);
      cmp("R1", "proc_all", proc_all, 0);
      cmp("R1", "split_mode", split_mode, 0);
      @(negedge clk); rst_n = 1'b1;

      bus(1, 1, 0, 6'h00, 8'h00);                 // R1: mode reads zero
      set_mode(8'hFF);                            // R2: reserved bit dropped
      bus(1, 1, 0, 6'h00, 8'h00);
      cmp("R2", "mode readback", rdata, 8'hDF);
      set_mode(8'h40);                            // R3: force-processor only
      bus(1, 1, 0, 6'h1F, 8'h00);

      // R6 R5: connection low, stream 3, channel ends
      set_mode(8'h13);
      mwr(5'd0, 8'hA1); mwr(5'd31, 8'hB2); mrd(5'd0); mrd(5'd31);
      // connection high, stream 7
      set_mode(8'h1F);
      mwr(5'd31, 8'h3C); mwr(5'd4, 8'h77); mrd(5'd31); mrd(5'd4);
      // data store select: read works, write dropped (R6)
      set_mode(8'h0A);
      mrd(5'd9); mwr(5'd9, 8'hEE); mrd(5'd9);
      // select 00: reads zero, write dropped
      set_mode(8'h02);
      mwr(5'd9, 8'h11); mrd(5'd9);
      set_mode(8'h12); mrd(5'd9);
      set_mode(8'h1A); mrd(5'd9);
      // R7: split, select low: reads from data store, writes to low half
      set_mode(8'h92);
      mwr(5'd5, 8'h99); mrd(5'd5);
      set_mode(8'h12); mrd(5'd5);
      // R9: no chip select, then both strobes
      bus(0, 1, 1, 6'h25, 8'h44);
      bus(0, 0, 1, 6'h00, 8'hFF);
      bus(1, 1, 0, 6'h00, 8'h00);
      bus(1, 1, 1, 6'h25, 8'h66);
      mrd(5'd5);
      cmp("R9", "both-strobe write", rdata, 8'h66);

      // Sweep every select and split combination
      lfsr = 8'h2B;
      for (int sp = 0; sp < 2; sp++) begin
         for (int ms = 0; ms < 4; ms++) begin
            for (int k = 0; k < 6; k++) begin
               lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
               set_mode({sp[0], lfsr[0], 1'b0, ms[1:0], lfsr[7:5]});
               mwr(lfsr[4:0], lfsr ^ 8'hA5);
               mrd(lfsr[4:0]);
               mrd(5'(lfsr[4:0] + 5'd1));
            end
         end
      end

      bus(0, 0, 0, 6'h00, 8'h00);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

endmodule